// File: doc/BRIEF.md
# Dual-Channel Partitioned DMA FIFO

This block is a single data store of `DEPTH` entries shared by two disk channels, a primary and a secondary. A 2-bit split input decides how the store is divided between them: the primary can take all of it, the secondary can take all of it, or each can take half. Each channel has its own write port, its own read port, an occupancy count, full and empty flags, an error pulse and a request output. The request goes high once the channel's fill level reaches a fraction of its share. The fraction is chosen per channel by a 2-bit code.

A channel's contents can be thrown away by a flush. Two events cause one. The first is the rising edge of that channel's interrupt, which counts only when the channel's interrupt-flush enable is set. The second is a sector-end strobe, which counts only when the channel's sector-flush enable is set. A change of the split value flushes both channels, because every stored position moves to a new owner. Read data is presented at the head of each channel without a read strobe, so `*_rdata` always shows the oldest entry.

Top module: `dual_chan_fifo`

## Requirements
- R1: After reset both counts are 0, both channels are empty and not full, and no request or error is high. The internal split register resets to 01.
- R2: Split code 00 gives the primary channel `DEPTH` entries and the secondary channel 0. Code 11 gives the primary 0 and the secondary `DEPTH`. Codes 01 and 10 each give `DEPTH/2` to both channels. A channel reports full when its count equals its share.
- R3: Each channel returns its data in the order it was written. `*_rdata` shows the oldest entry whenever the channel is not empty.
- R4: An accepted write raises the count by 1 at the next clock edge, and an accepted read lowers it by 1. A read and a write accepted in the same cycle leave the count unchanged.
- R5: A write to a full channel is ignored, and that channel's `*_err` is high for the following cycle only.
- R6: A read from an empty channel is ignored, and that channel's `*_err` is high for the following cycle only.
- R7: A channel whose share is 0 shows full and empty together, never raises its request, and rejects writes with an error pulse.
- R8: Threshold code 00 selects the full share, 01 three quarters, 10 one half and 11 one quarter. The level is the share times the fraction, rounded down, and never less than 1. `*_req` is high while the count is at or above that level.
- R9: While a channel's interrupt-flush enable is 1, a rising edge on its interrupt input empties that channel at the next clock edge. Keeping the interrupt high does not flush again.
- R10: While a channel's interrupt-flush enable is 0, its interrupt input has no effect on its contents.
- R11: While a channel's sector-flush enable is 1, a sector-end strobe empties that channel at the next clock edge. While the enable is 0, the strobe has no effect.
- R12: A flush of one channel leaves the count and data of the other channel unchanged. Reads and writes on a channel in its flush cycle are ignored, and they raise no error.
- R13: A split value that differs from the one in use is taken at the next clock edge, and both channels are flushed at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| split_sel | input | 2 | Partition code for the store |
| p_thr | input | 2 | Primary threshold fraction code |
| s_thr | input | 2 | Secondary threshold fraction code |
| p_irq_flush_en | input | 1 | Primary interrupt-flush enable |
| s_irq_flush_en | input | 1 | Secondary interrupt-flush enable |
| p_sect_flush_en | input | 1 | Primary sector-flush enable |
| s_sect_flush_en | input | 1 | Secondary sector-flush enable |
| p_irq | input | 1 | Primary interrupt level |
| s_irq | input | 1 | Secondary interrupt level |
| p_sect_end | input | 1 | Primary sector-end strobe |
| s_sect_end | input | 1 | Secondary sector-end strobe |
| p_wr | input | 1 | Primary write strobe |
| p_wdata | input | DW | Primary write data |
| p_rd | input | 1 | Primary read strobe |
| p_rdata | output | DW | Primary head-of-queue data |
| p_count | output | $clog2(DEPTH)+1 | Primary occupancy |
| p_full | output | 1 | Primary full |
| p_empty | output | 1 | Primary empty |
| p_req | output | 1 | Primary threshold request |
| p_err | output | 1 | Primary overflow/underflow pulse |
| s_wr | input | 1 | Secondary write strobe |
| s_wdata | input | DW | Secondary write data |
| s_rd | input | 1 | Secondary read strobe |
| s_rdata | output | DW | Secondary head-of-queue data |
| s_count | output | $clog2(DEPTH)+1 | Secondary occupancy |
| s_full | output | 1 | Secondary full |
| s_empty | output | 1 | Secondary empty |
| s_req | output | 1 | Secondary threshold request |
| s_err | output | 1 | Secondary overflow/underflow pulse |

## Verification
The bench uses the default parameters, `DEPTH` = 16 and `DW` = 8. With these, the shares seen are 16, 8 and 0, and every threshold code falls on a whole entry: 16, 12, 8 and 4 for a full store, and 8, 6, 4 and 2 for a half. These values let the bench run the request edge, overflow of every share and a zero-share channel in a few hundred cycles. The clamp of the level to 1 never applies at these sizes, so the bench cannot reach it.

// File: rtl/dual_chan_fifo.sv
module dual_chan_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 split_sel,
  input  logic [1:0]                 p_thr,
  input  logic [1:0]                 s_thr,
  input  logic                       p_irq_flush_en,
  input  logic                       s_irq_flush_en,
  input  logic                       p_sect_flush_en,
  input  logic                       s_sect_flush_en,
  input  logic                       p_irq,
  input  logic                       s_irq,
  input  logic                       p_sect_end,
  input  logic                       s_sect_end,
  input  logic                       p_wr,
  input  logic [DW-1:0]              p_wdata,
  input  logic                       p_rd,
  output logic [DW-1:0]              p_rdata,
  output logic [$clog2(DEPTH):0]     p_count,
  output logic                       p_full,
  output logic                       p_empty,
  output logic                       p_req,
  output logic                       p_err,
  input  logic                       s_wr,
  input  logic [DW-1:0]              s_wdata,
  input  logic                       s_rd,
  output logic [DW-1:0]              s_rdata,
  output logic [$clog2(DEPTH):0]     s_count,
  output logic                       s_full,
  output logic                       s_empty,
  output logic                       s_req,
  output logic                       s_err
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    split_q;
  logic [1:0]    irq_q;
  logic          split_chg;

  logic [1:0][CW-1:0] sh_v, base_v, cnt_v;
  logic [1:0][1:0]    thr_v;
  logic [1:0][AW-1:0] waddr_v, raddr_v;
  logic [1:0][DW-1:0] wdata_v;
  logic [1:0]         wr_v, rd_v, wok_v, flush_v, full_v, empty_v, req_v, err_v;

  function automatic logic [CW-1:0] level(input logic [CW-1:0] sh, input logic [1:0] code);
    logic [CW+1:0] t;
    logic [CW+1:0] s;
    s = {2'b00, sh};
    case (code)
      2'b00:   t = s;
      2'b01:   t = ((s << 1) + s) >> 2;
      2'b10:   t = s >> 1;
      default: t = s >> 2;
    endcase
    if (t == '0) t = 1;
    return t[CW-1:0];
  endfunction

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [CW-1:0] sh);
    return ({1'b0, p} == sh - 1'b1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (split_q)
      2'b00:   begin sh_v[0] = CW'(DEPTH); sh_v[1] = '0;         end
      2'b11:   begin sh_v[0] = '0;         sh_v[1] = CW'(DEPTH); end
      default: begin sh_v[0] = CW'(HALF);  sh_v[1] = CW'(HALF);  end
    endcase
  end

  assign base_v[0] = '0;
  assign base_v[1] = sh_v[0];
  assign split_chg = (split_sel != split_q);

  assign thr_v   = {s_thr, p_thr};
  assign wr_v    = {s_wr, p_wr};
  assign rd_v    = {s_rd, p_rd};
  assign wdata_v = {s_wdata, p_wdata};

  assign flush_v[0] = split_chg | (p_irq_flush_en & p_irq & ~irq_q[0]) | (p_sect_flush_en & p_sect_end);
  assign flush_v[1] = split_chg | (s_irq_flush_en & s_irq & ~irq_q[1]) | (s_sect_flush_en & s_sect_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= 2'b01;
      irq_q   <= '0;
    end else begin
      split_q <= split_sel;
      irq_q   <= {s_irq, p_irq};
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          err_q, full, empty, wok, rok;

    assign full  = (cnt == sh_v[g]);
    assign empty = (cnt == '0);
    assign wok   = wr_v[g] & ~full  & ~flush_v[g];
    assign rok   = rd_v[g] & ~empty & ~flush_v[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0; err_q <= 1'b0;
      end else begin
        err_q <= ~flush_v[g] & ((wr_v[g] & full) | (rd_v[g] & empty));
        if (flush_v[g]) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else begin
          if (wok) wp <= adv(wp, sh_v[g]);
          if (rok) rp <= adv(rp, sh_v[g]);
          cnt <= cnt + CW'(wok) - CW'(rok);
        end
      end
    end

    assign cnt_v[g]   = cnt;
    assign full_v[g]  = full;
    assign empty_v[g] = empty;
    assign err_v[g]   = err_q;
    assign wok_v[g]   = wok;
    assign req_v[g]   = (sh_v[g] != '0) && (cnt >= level(sh_v[g], thr_v[g]));
    assign waddr_v[g] = AW'(base_v[g] + CW'(wp));
    assign raddr_v[g] = AW'(base_v[g] + CW'(rp));
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++)
      if (wok_v[c]) mem[waddr_v[c]] <= wdata_v[c];
  end

  assign p_rdata = mem[raddr_v[0]];
  assign s_rdata = mem[raddr_v[1]];
  assign p_count = cnt_v[0];
  assign s_count = cnt_v[1];
  assign p_full  = full_v[0];
  assign s_full  = full_v[1];
  assign p_empty = empty_v[0];
  assign s_empty = empty_v[1];
  assign p_req   = req_v[0];
  assign s_req   = req_v[1];
  assign p_err   = err_v[0];
  assign s_err   = err_v[1];
endmodule

module dual_chan_fifo_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    flush,
  input logic [CW-1:0] sh_p,
  input logic [CW-1:0] sh_s,
  input logic [CW-1:0] p_count,
  input logic [CW-1:0] s_count,
  input logic          p_wr,
  input logic          p_rd,
  input logic          s_wr,
  input logic          s_rd,
  input logic          p_full,
  input logic          p_empty,
  input logic          s_full,
  input logic          s_empty,
  input logic          p_req,
  input logic          s_req,
  input logic          p_err,
  input logic          s_err
);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_count <= sh_p) && (s_count <= sh_s));
  // R5
  over_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_wr && p_full && !flush[0]) |=> p_err);
  // R6
  under_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd && s_empty && !flush[1]) |=> s_err);
  // R4
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_wr && p_rd && !p_full && !p_empty && !flush[0]) |=> $stable(p_count));
  // R12
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |=> (s_count == '0));
  // R7
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_s == '0) |-> (!s_req && s_full && s_empty));
  // R8
  req_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_req |-> (p_count != '0));
endmodule

bind dual_chan_fifo dual_chan_fifo_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush_v),
  .sh_p(sh_v[0]), .sh_s(sh_v[1]),
  .p_count(p_count), .s_count(s_count),
  .p_wr(p_wr), .p_rd(p_rd), .s_wr(s_wr), .s_rd(s_rd),
  .p_full(p_full), .p_empty(p_empty), .s_full(s_full), .s_empty(s_empty),
  .p_req(p_req), .s_req(s_req), .p_err(p_err), .s_err(s_err)
);

// File: tb/sim_dual_chan_fifo.sv
module sim_dual_chan_fifo;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] split_sel = 2'b01, p_thr = 2'b10, s_thr = 2'b10;
  logic p_irq_flush_en = 1, s_irq_flush_en = 1, p_sect_flush_en = 0, s_sect_flush_en = 0;
  logic p_irq = 0, s_irq = 0, p_sect_end = 0, s_sect_end = 0;
  logic p_wr = 0, p_rd = 0, s_wr = 0, s_rd = 0;
  logic [DW-1:0] p_wdata = 0, s_wdata = 0;
  logic [DW-1:0] p_rdata, s_rdata;
  logic [CW-1:0] p_count, s_count;
  logic p_full, p_empty, p_req, p_err, s_full, s_empty, s_req, s_err;

  always #5 clk = ~clk;

  dual_chan_fifo #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

  int nchk = 0, nerr = 0;
  logic [DW-1:0] q0[$], q1[$];
  int mc[2], sh[2];
  logic [1:0] split_m = 2'b01;
  logic [1:0] irq_prev = 2'b00;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lvl(input int s, input logic [1:0] c);
    int t;
    case (c)
      2'b00: t = s;
      2'b01: t = (s * 3) / 4;
      2'b10: t = s / 2;
      default: t = s / 4;
    endcase
    return (t < 1) ? 1 : t;
  endfunction

  function automatic void set_shares(input logic [1:0] s);
    case (s)
      2'b00: begin sh[0] = DEPTH; sh[1] = 0; end
      2'b11: begin sh[0] = 0; sh[1] = DEPTH; end
      default: begin sh[0] = DEPTH / 2; sh[1] = DEPTH / 2; end
    endcase
  endfunction

  task automatic step(input bit pw, input logic [DW-1:0] pd, input bit pr,
                      input bit sw, input logic [DW-1:0] sd, input bit sr);
    bit f[2], w[2], r[2], wok[2], rok[2], eerr[2], chg;
    int exq;
    p_wr = pw; p_wdata = pd; p_rd = pr;
    s_wr = sw; s_wdata = sd; s_rd = sr;
    w[0] = pw; w[1] = sw; r[0] = pr; r[1] = sr;
    #1;
    chg  = (split_sel != split_m);
    f[0] = chg || (p_irq_flush_en && p_irq && !irq_prev[0]) || (p_sect_flush_en && p_sect_end);
    f[1] = chg || (s_irq_flush_en && s_irq && !irq_prev[1]) || (s_sect_flush_en && s_sect_end);
    for (int c = 0; c < 2; c++) begin
      wok[c]  = w[c] && (mc[c] != sh[c]) && !f[c];
      rok[c]  = r[c] && (mc[c] != 0) && !f[c];
      eerr[c] = !f[c] && ((w[c] && mc[c] == sh[c]) || (r[c] && mc[c] == 0));
    end
    // monitor: pop expected head and compare (R3)
    if (rok[0]) begin exq = q0.pop_front(); chk("R3 p_rdata order", p_rdata, exq); end
    if (rok[1]) begin exq = q1.pop_front(); chk("R3 s_rdata order", s_rdata, exq); end
    @(posedge clk);
    if (f[0]) q0.delete(); else if (wok[0]) q0.push_back(pd);
    if (f[1]) q1.delete(); else if (wok[1]) q1.push_back(sd);
    for (int c = 0; c < 2; c++)
      mc[c] = f[c] ? 0 : mc[c] + int'(wok[c]) - int'(rok[c]);
    irq_prev = {s_irq, p_irq};
    if (chg) begin split_m = split_sel; set_shares(split_m); end
    @(negedge clk);
    p_wr = 0; p_rd = 0; s_wr = 0; s_rd = 0; p_sect_end = 0; s_sect_end = 0;
    chk("R4 R9 R10 R11 R12 R13 p_count", p_count, mc[0]);
    chk("R4 R9 R10 R11 R12 R13 s_count", s_count, mc[1]);
    chk("R2 R7 p_full", p_full, mc[0] == sh[0]);
    chk("R2 R7 s_full", s_full, mc[1] == sh[1]);
    chk("R7 p_empty", p_empty, mc[0] == 0);
    chk("R7 s_empty", s_empty, mc[1] == 0);
    chk("R8 p_req", p_req, sh[0] != 0 && mc[0] >= lvl(sh[0], p_thr));
    chk("R8 s_req", s_req, sh[1] != 0 && mc[1] >= lvl(sh[1], s_thr));
    chk("R5 R6 p_err", p_err, eerr[0]);
    chk("R5 R6 s_err", s_err, eerr[1]);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    set_shares(2'b01);
    mc[0] = 0; mc[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 p_count", p_count, 0);   chk("R1 s_count", s_count, 0);
    chk("R1 p_empty", p_empty, 1);   chk("R1 s_full", s_full, 0);
    chk("R1 p_req", p_req, 0);       chk("R1 s_err", s_err, 0);
    idle();
    // R3 R5 R8: fill primary past its half share
    for (int i = 0; i < 9; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0);
    // R6: drain and underflow
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, 0);
    // R4: simultaneous read and write
    step(1, 8'hA0, 0, 1, 8'hB0, 0);
    step(1, 8'hA1, 0, 1, 8'hB1, 0);
    for (int i = 0; i < 5; i++) step(1, 8'hC0 + 8'(i), 1, 1, 8'hD0 + 8'(i), 1);
    // R8: every threshold code on half shares
    for (int t = 0; t < 4; t++) begin
      p_thr = 2'(t); s_thr = 2'(3 - t);
      for (int i = 0; i < 7; i++) step(1, 8'(t * 16 + i), 0, 1, 8'(t * 16 + i + 8), 0);
      for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 1);
    end
    // R13: split change with data present flushes both
    step(1, 8'h01, 0, 1, 8'h02, 0);
    split_sel = 2'b00;
    idle();
    // R2 R7: primary takes all, secondary has zero share
    for (int i = 0; i < 17; i++) step(1, 8'h40 + 8'(i), 0, 1, 8'h55, 0);
    for (int t = 0; t < 4; t++) begin
      p_thr = 2'(t);
      for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 5; i++) step(1, 8'h60 + 8'(i), 0, 0, 0, 0);
    end
    for (int i = 0; i < 17; i++) step(0, 0, 1, 0, 0, 0);
    split_sel = 2'b11;
    idle();
    for (int i = 0; i < 17; i++) step(1, 8'h70, 0, 1, 8'h80 + 8'(i), 0);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1);
    split_sel = 2'b10;
    idle();
    // R9 R12: interrupt flush of primary only
    for (int i = 0; i < 3; i++) step(1, 8'h90 + 8'(i), 0, 1, 8'hE0 + 8'(i), 0);
    p_irq = 1;
    step(1, 8'h99, 1, 0, 0, 0);
    step(1, 8'h9A, 0, 0, 0, 0);
    p_irq = 0;
    step(0, 0, 0, 0, 0, 1);
    // R10: interrupt flush disabled on secondary
    s_irq_flush_en = 0; s_irq = 1;
    step(0, 0, 0, 1, 8'hE5, 0);
    s_irq = 0;
    idle();
    // R11: sector flush enabled then disabled
    s_sect_flush_en = 1; s_sect_end = 1;
    step(1, 8'h9B, 0, 0, 0, 0);
    step(0, 0, 0, 1, 8'hF0, 0);
    s_sect_flush_en = 0; s_sect_end = 1;
    step(0, 0, 0, 1, 8'hF1, 0);
    p_sect_flush_en = 1; p_sect_end = 1;
    idle();
    p_sect_flush_en = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 1);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule